// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static memory that is one bit wide and has a 16-bit address. The host issues single-cycle requests, each naming a read or a write, an address and a write bit. The controller turns each request into the select, write-strobe, address and data-in waveform that the memory expects. On a read it samples the memory's data-out line and returns the bit with a one-cycle valid pulse.

Every phase of an access lasts a whole number of clock cycles. Each count is the ceiling of a minimum memory time divided by the clock period, and both the times and the clock period are parameters. A write lasts only while select and write strobe are both low. The controller always ends it by raising the write strobe first, so the setup and hold windows for data and address are measured from that rising edge. Between accesses the memory is deselected, which leaves it in its low-power standby state. New requests are taken only while the busy flag is low.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and after it is released, with no request: mem_sel_n and mem_wr_n are 1, busy is 0 and rd_valid is 0.
- R2: mem_wr_n goes low only while mem_sel_n is low and has been low for at least one full clock before. At the end of the write, the strobe low time is at least T_PWE_NS and the select low time is at least T_SCE_NS.
- R3: A write stores host_wdata at host_addr (host_wr = 1 selects a write). mem_din has been stable for at least T_SD_NS, and mem_addr for at least T_AW_NS, when mem_wr_n rises.
- R4: After a write, mem_wr_n rises at least one full clock before mem_sel_n rises. Address and data do not change before that.
- R5: The select low time of a write access is at least T_WC_NS.
- R6: A read (host_wr = 0) keeps mem_wr_n at 1 and samples mem_dout no earlier than max(T_AA_NS, T_ACE_NS) after the address and select were applied. rd_data equals the bit last written to that address, or 0 if the address was never written.
- R7: rd_valid is a single-cycle pulse, given exactly once for each read and never for a write.
- R8: busy rises in the cycle after a request is accepted. It stays high for WLOW+2 cycles on a write and RD cycles on a read, where RD = ceil(max(T_AA_NS, T_ACE_NS)/CLK_PERIOD_NS) and WLOW is the write-strobe cycle count. A request raised while busy is 1 is ignored and causes no memory access.
- R9: Whenever busy is 0, mem_sel_n and mem_wr_n are both 1, so the memory is in standby between accesses.
- R10: While busy is 1, mem_addr and mem_din do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, taken when busy is 0 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Access address |
| host_wdata | input | 1 | Bit to write |
| busy | output | 1 | Access in progress |
| rd_data | output | 1 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_din | output | 1 | Memory data input |
| mem_dout | input | 1 | Memory data output |

## Verification
The hardest case to reach from the ports is a sample taken too early. That requires memory data that is wrong until the access time has passed, and a real part would simply keep its old value. The bench's memory model therefore drives the inverse of the stored bit until its access time has elapsed since the last change of address, select or strobe. An early capture then returns a wrong bit instead of a correct one by chance. The model also timestamps every edge of the write strobe, select, address and data, so each write's setup and hold windows are measured in nanoseconds. Finally, a second request is injected while a write is busy, and a later read of its address shows that the request had no effect.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/10ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_WAIT
    } ctrl_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/10ps
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/10ps
module sram_rd_capture (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic sample,
    output logic data,
    output logic valid
);

    typedef struct packed {
        logic data;
        logic valid;
    } cap_s;

    cap_s cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = capture;
        if (capture) begin
            cap_d.data = sample;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign data  = cap_q.data;
    assign valid = cap_q.valid;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/10ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_AA_NS       = 15,
    parameter int T_ACE_NS      = 15,
    parameter int T_PWE_NS      = 12,
    parameter int T_SCE_NS      = 12,
    parameter int T_AW_NS       = 12,
    parameter int T_SD_NS       = 10,
    parameter int T_WC_NS       = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wdata,
    output logic              busy,
    output logic              rd_data,
    output logic              rd_valid,
    output logic              mem_sel_n,
    output logic              mem_wr_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_din,
    input  logic              mem_dout
);

    // Read capture: the later of address-to-data and select-to-data.
    localparam int RD_CYC = imax(ceil_div(T_AA_NS, CLK_PERIOD_NS),
                                 ceil_div(T_ACE_NS, CLK_PERIOD_NS));
    // Strobe-low length; the setup cycle before it and the hold cycle
    // after it count toward the select, address and cycle minimums.
    localparam int WLOW_A   = imax(ceil_div(T_PWE_NS, CLK_PERIOD_NS),
                                   ceil_div(T_SD_NS, CLK_PERIOD_NS));
    localparam int WLOW_B   = imax(ceil_div(T_AW_NS, CLK_PERIOD_NS) - 1,
                                   ceil_div(T_SCE_NS, CLK_PERIOD_NS) - 1);
    localparam int WLOW_C   = imax(ceil_div(T_WC_NS, CLK_PERIOD_NS) - 2, 1);
    localparam int WLOW_CYC = imax(imax(WLOW_A, WLOW_B), WLOW_C);
    localparam int CNT_MAX  = imax(RD_CYC, WLOW_CYC);
    localparam int CNT_W    = imax($clog2(CNT_MAX + 1), 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WLOW_LOAD = CNT_W'(WLOW_CYC - 1);

    generate
        if (RD_CYC < 1) begin : g_bad_rd_delay
            $error("read capture delay resolves to zero cycles");
        end
    endgenerate

    typedef struct packed {
        ctrl_state_e       state;
        logic              sel_n;
        logic              wr_n;
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic              din;
    } ctrl_s;

    localparam ctrl_s CTRL_RESET = '{
        state: ST_IDLE,
        sel_n: 1'b1,
        wr_n:  1'b1,
        busy:  1'b0,
        addr:  '0,
        din:   1'b0
    };

    ctrl_s             ctrl_d, ctrl_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              cap_en;

    always_comb begin
        ctrl_d   = ctrl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (host_req) begin
                    ctrl_d.busy  = 1'b1;
                    ctrl_d.sel_n = 1'b0;
                    ctrl_d.addr  = host_addr;
                    if (host_wr) begin
                        ctrl_d.din   = host_wdata;
                        ctrl_d.state = ST_WR_SETUP;
                    end else begin
                        ctrl_d.state = ST_RD_WAIT;
                        tmr_load     = 1'b1;
                        tmr_val      = RD_LOAD;
                    end
                end
            end
            ST_WR_SETUP: begin
                ctrl_d.wr_n  = 1'b0;
                ctrl_d.state = ST_WR_PULSE;
                tmr_load     = 1'b1;
                tmr_val      = WLOW_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    ctrl_d.wr_n  = 1'b1;
                    ctrl_d.state = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                ctrl_d.sel_n = 1'b1;
                ctrl_d.busy  = 1'b0;
                ctrl_d.state = ST_IDLE;
            end
            ST_RD_WAIT: begin
                if (tmr_zero) begin
                    cap_en       = 1'b1;
                    ctrl_d.sel_n = 1'b1;
                    ctrl_d.busy  = 1'b0;
                    ctrl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctrl_d = CTRL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_rd_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .capture (cap_en),
        .sample  (mem_dout),
        .data    (rd_data),
        .valid   (rd_valid)
    );

    assign busy      = ctrl_q.busy;
    assign mem_sel_n = ctrl_q.sel_n;
    assign mem_wr_n  = ctrl_q.wr_n;
    assign mem_addr  = ctrl_q.addr;
    assign mem_din   = ctrl_q.din;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/10ps
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic              busy,
    input logic              rd_valid,
    input logic              mem_sel_n,
    input logic              mem_wr_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_din
);

    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> !mem_sel_n); // R2

    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |-> $past(!mem_sel_n)); // R2

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_sel_n) |-> $past(mem_wr_n) && mem_wr_n); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R7

    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(mem_wr_n)); // R6

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        host_req && !busy |=> busy); // R8

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> mem_sel_n && mem_wr_n); // R9

    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mem_addr) && $stable(mem_din)); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_req  (host_req),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .mem_sel_n (mem_sel_n),
    .mem_wr_n  (mem_wr_n),
    .mem_addr  (mem_addr),
    .mem_din   (mem_din)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/10ps
module sram_async_ctrl_tb;

    localparam real CLK_NS      = 5.0;
    localparam real T_MODEL_AA  = 14.5;
    localparam int  EXP_RD_BUSY = 3;   // ceil(15/5)
    localparam int  EXP_WR_BUSY = 5;   // 1 setup + ceil(12/5) strobe + 1 hold

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_wdata = 1'b0;
    logic        busy, rd_data, rd_valid, mem_sel_n, mem_wr_n, mem_din;
    logic [15:0] mem_addr;
    logic        mem_dout;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    sram_async_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .mem_sel_n  (mem_sel_n),
        .mem_wr_n   (mem_wr_n),
        .mem_addr   (mem_addr),
        .mem_din    (mem_din),
        .mem_dout   (mem_dout)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- memory model ----------------
    bit  mem [int];
    bit  exp_mem [int];
    int  model_writes = 0;
    int  exp_writes = 0;
    bit  in_wr = 0;
    real t_addr = 0.0, t_din = 0.0, t_sel_fall = 0.0;
    real t_wr_fall = 0.0, t_wr_rise = 0.0, t_rchg = 0.0;

    always @(mem_addr) t_addr = $realtime;
    always @(mem_din) t_din = $realtime;
    always @(mem_addr or mem_sel_n or mem_wr_n) t_rchg = $realtime;
    always @(negedge mem_sel_n) t_sel_fall = $realtime;

    task automatic write_end();
        real now;
        now = $realtime;
        chk(now - t_wr_fall >= 12.0, "R2 strobe low ns", $rtoi(now - t_wr_fall), 12);
        chk(now - t_sel_fall >= 12.0, "R2 select low ns", $rtoi(now - t_sel_fall), 12);
        chk(now - t_din >= 10.0, "R3 data setup ns", $rtoi(now - t_din), 10);
        chk(now - t_addr >= 12.0, "R3 addr setup ns", $rtoi(now - t_addr), 12);
        mem[int'(mem_addr)] = mem_din;
        model_writes++;
    endtask

    always @(negedge mem_wr_n) begin
        t_wr_fall = $realtime;
        in_wr = 1;
        chk(mem_sel_n === 1'b0 && ($realtime - t_sel_fall) >= CLK_NS,
            "R2 select before strobe ns", $rtoi($realtime - t_sel_fall), 5);
    end

    always @(posedge mem_wr_n) begin
        t_wr_rise = $realtime;
        if (mem_sel_n === 1'b0) write_end();
    end

    always @(posedge mem_sel_n) begin
        if (mem_wr_n === 1'b0) write_end();
        if (in_wr) begin
            in_wr = 0;
            chk($realtime - t_sel_fall >= 15.0, "R5 write cycle ns",
                $rtoi($realtime - t_sel_fall), 15);
            chk($realtime - t_wr_rise >= CLK_NS, "R4 strobe-to-deselect ns",
                $rtoi($realtime - t_wr_rise), 5);
        end
    end

    // Data out is the inverse of the stored bit until the access time has passed.
    initial begin
        bit v;
        mem_dout = 1'b0;
        #0.25;
        forever begin
            v = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 1'b0;
            if (mem_sel_n === 1'b0 && mem_wr_n === 1'b1 && ($realtime - t_rchg) >= T_MODEL_AA)
                mem_dout = v;
            else
                mem_dout = ~v;
            #0.5;
        end
    end

    // ---------------- scoreboard ----------------
    bit exp_q [$];
    int reads_issued = 0;
    int valids_seen = 0;
    bit prev_valid = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                valids_seen++;
                chk(!prev_valid, "R7 valid width", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(0, "R7 valid without read", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R6 read data", rd_data, e);
                end
            end
            prev_valid = rd_valid;
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input bit d, input bit inject);
        int n;
        @(negedge clk);
        while (busy) @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 0;
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        n = 0;
        while (busy) begin
            n++;
            if (inject && n == 1) begin
                host_req = 1; host_wr = 1; host_addr = 16'h0099; host_wdata = 1;
            end else begin
                host_req = 0;
            end
            @(negedge clk);
        end
        host_req = 0;
        chk(n == (wr ? EXP_WR_BUSY : EXP_RD_BUSY), "R8 busy cycles", n,
            wr ? EXP_WR_BUSY : EXP_RD_BUSY);
        chk(mem_sel_n == 1'b1 && mem_wr_n == 1'b1, "R9 standby when idle",
            {mem_sel_n, mem_wr_n}, 3);
    endtask

    task automatic do_write(input logic [15:0] a, input bit d, input bit inject);
        exp_mem[int'(a)] = d;
        exp_writes++;
        issue(1'b1, a, d, inject);
    endtask

    task automatic do_read(input logic [15:0] a);
        exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 1'b0);
        reads_issued++;
        issue(1'b0, a, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_sel_n == 1 && mem_wr_n == 1, "R1 reset strobes", {mem_sel_n, mem_wr_n}, 3);
        chk(busy == 0 && rd_valid == 0, "R1 reset busy/valid", {busy, rd_valid}, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk(mem_sel_n == 1 && mem_wr_n == 1 && busy == 0 && rd_valid == 0,
            "R1 idle after reset", {mem_sel_n, mem_wr_n, busy, rd_valid}, 12);

        do_write(16'h0000, 1'b1, 1'b0);
        do_write(16'hFFFF, 1'b1, 1'b0);
        do_write(16'h1234, 1'b0, 1'b0);
        do_write(16'h5555, 1'b1, 1'b1);   // ignored request to 0x0099 during busy (R8)
        do_write(16'h0001, 1'b1, 1'b0);
        do_write(16'h0001, 1'b0, 1'b0);   // overwrite
        do_write(16'hA5A5, 1'b1, 1'b0);

        do_read(16'h0000);
        do_read(16'hFFFF);
        do_read(16'h1234);
        do_read(16'h5555);
        do_read(16'h0099);                // R8: never written, expect 0
        do_read(16'h0001);
        do_read(16'h7777);                // unwritten
        do_read(16'hA5A5);
        do_write(16'h1234, 1'b1, 1'b0);
        do_read(16'h1234);
        do_read(16'h1234);

        repeat (4) @(negedge clk);
        chk(model_writes == exp_writes, "R3 write count (R6 reads write nothing)",
            model_writes, exp_writes);
        chk(valids_seen == reads_issued, "R7 valid count", valids_seen, reads_issued);
        chk(exp_q.size() == 0, "R7 pending reads", exp_q.size(), 0);
        chk(mem_sel_n == 1 && busy == 0, "R9 final standby", {mem_sel_n, busy}, 2);
        finish_run();
    end

endmodule